// File: doc/BRIEF.md
# Auto-Incrementing Indirect Register Loader

This block gives the CPU a second way into the control register file. It holds a pointer register at index 17. The pointer carries a target register number and a flag that stops the pointer from moving. Each byte the CPU writes to the indirect data port goes to the register the pointer names. Unless the flag is set, the pointer then moves on by one. A run of consecutive registers can therefore be filled by back-to-back data writes. The usual case is a 15-byte parameter burst for the drawing engine, which starts at register 32 and ends with the command code in register 46.

Register writes that come in on the direct path are decoded outside this block and arrive here as an address-and-data strobe. Both paths are merged into one registered write strobe for the register file. A write to register 46 from either path sends a command to the drawing engine. The block drives a one-cycle start pulse and keeps a busy flag, which the engine clears with a done pulse. A command issued while the engine is busy aborts the running one. A command code whose upper nibble is zero is a stop request: it aborts any running command and starts nothing.

Top module: `ind_write_port`

## Requirements
- R1: After reset the pointer reads 0x00, busy is low, and the rf_we, cmd_start and cmd_abort outputs are low.
- R2: A direct write to register 17 loads the pointer. Bit 7 becomes the auto-increment inhibit flag, bits 5:0 become the target register number, and bit 6 always reads 0. The new value shows on ptr one cycle after the write.
- R3: An indirect data write raises rf_we for exactly one cycle, one cycle after the write. In that cycle rf_addr equals the target number the pointer held at the time of the write, and rf_data equals the written byte.
- R4: After each accepted indirect write, the pointer target advances by one when bit 7 is 0 and stays unchanged when bit 7 is 1. Bit 7 itself does not change.
- R5: The pointer target wraps from 63 to 0.
- R6: Writes to register numbers 47 to 63, from either path, produce no rf_we. An indirect write to such a number still advances the pointer.
- R7: An indirect write whose target is 17 produces no rf_we and does not load the pointer. The pointer advances as in R4.
- R8: A write to register 46 from either path whose data bits 7:4 are not zero gives a one-cycle cmd_start pulse and sets busy. Both take effect one cycle after the write. The write is also forwarded on rf_we.
- R9: busy clears one cycle after an eng_done pulse. If eng_done and a command write arrive in the same cycle, busy stays set.
- R10: A write to register 46 while busy is high gives a one-cycle cmd_abort pulse. If the data bits 7:4 are zero (stop), no cmd_start is given and busy clears.
- R11: When a direct write and an indirect write arrive in the same cycle, the direct write goes to the register file. The indirect byte is dropped and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_we | input | 1 | Direct-path register write strobe |
| dir_addr | input | 6 | Direct-path register number |
| dir_data | input | 8 | Direct-path write data |
| ind_we | input | 1 | Indirect data port write strobe |
| ind_data | input | 8 | Indirect data port byte |
| eng_done | input | 1 | Drawing engine finished pulse |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | 6 | Register file write index |
| rf_data | output | 8 | Register file write data |
| ptr | output | 8 | Current pointer register value |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_abort | output | 1 | One-cycle abort pulse for the running command |
| busy | output | 1 | Command in progress |

## Verification
The assertions assume the inputs carry known values from the first cycle after reset. They also assume eng_done arrives as a pulse; this is a property of the engine, not of this block. Every increment check conditions on a lone indirect write, because a simultaneous direct write wins by design. The bench changes inputs only on the falling clock edge. It holds every strobe low during reset, and it checks results on the falling edge after the write has been captured. Each strobe therefore lasts exactly one sampled cycle.

// File: rtl/ind_pkg.sv
package ind_pkg;

    // Which path owns the register file write in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DIR  = 2'd1,
        SRC_IND  = 2'd2
    } wr_src_e;

    // A command code whose upper nibble is zero is a stop request.
    localparam int unsigned OPC_MSB = 7;
    localparam int unsigned OPC_LSB = 4;

endpackage

// File: rtl/ind_wr_route.sv
module ind_wr_route
    import ind_pkg::*;
#(
    parameter int unsigned AW       = 6,
    parameter int unsigned DW       = 8,
    parameter int unsigned NUM_REGS = 47,
    parameter int unsigned PTR_REG  = 17
) (
    input  logic          dir_we,
    input  logic [AW-1:0] dir_addr,
    input  logic [DW-1:0] dir_data,
    input  logic          ind_we,
    input  logic [DW-1:0] ind_data,
    input  logic [AW-1:0] ind_target,
    output wr_src_e       src,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          ind_accept,
    output logic          ptr_load
);
    localparam logic [AW-1:0] PTR_IDX = AW'(PTR_REG);

    // An index outside the register file is dropped.
    function automatic logic exists(input logic [AW-1:0] a);
        return (32'(a) < NUM_REGS);
    endfunction

    always_comb begin
        src        = SRC_NONE;
        we         = 1'b0;
        addr       = '0;
        data       = '0;
        ind_accept = 1'b0;
        ptr_load   = 1'b0;
        if (dir_we) begin
            src      = SRC_DIR;
            addr     = dir_addr;
            data     = dir_data;
            we       = exists(dir_addr);
            ptr_load = (dir_addr == PTR_IDX);
        end else if (ind_we) begin
            src        = SRC_IND;
            addr       = ind_target;
            data       = ind_data;
            ind_accept = 1'b1;
            // The pointer never writes itself through the data port.
            we         = exists(ind_target) && (ind_target != PTR_IDX);
        end
    end

endmodule

// File: rtl/ind_ptr_next.sv
module ind_ptr_next #(
    parameter int unsigned AW      = 6,
    parameter int unsigned DW      = 8,
    parameter int unsigned INH_BIT = 7
) (
    input  logic [DW-1:0] ptr_q,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          advance,
    output logic [DW-1:0] ptr_d
);
    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            // Only the flag and the target field are stored; the rest is zero.
            ptr_d              = '0;
            ptr_d[INH_BIT]     = load_data[INH_BIT];
            ptr_d[AW-1:0]      = load_data[AW-1:0];
        end else if (advance && !ptr_q[INH_BIT]) begin
            ptr_d[AW-1:0] = ptr_q[AW-1:0] + AW'(1);
        end
    end

endmodule

// File: rtl/ind_cmd_ctl.sv
module ind_cmd_ctl
    import ind_pkg::*;
#(
    parameter int unsigned AW      = 6,
    parameter int unsigned DW      = 8,
    parameter int unsigned CMD_REG = 46
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          busy_q,
    input  logic          eng_done,
    output logic          busy_d,
    output logic          start_d,
    output logic          abort_d
);
    localparam logic [AW-1:0] CMD_IDX = AW'(CMD_REG);

    logic cmd_hit;
    logic is_stop;

    always_comb begin
        cmd_hit = we && (addr == CMD_IDX);
        is_stop = (data[OPC_MSB:OPC_LSB] == '0);
        busy_d  = busy_q && !eng_done;
        start_d = 1'b0;
        abort_d = 1'b0;
        if (cmd_hit) begin
            abort_d = busy_q;
            if (is_stop) begin
                busy_d = 1'b0;
            end else begin
                start_d = 1'b1;
                busy_d  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ind_write_port.sv
module ind_write_port
    import ind_pkg::*;
#(
    parameter int unsigned AW       = 6,
    parameter int unsigned DW       = 8,
    parameter int unsigned NUM_REGS = 47,
    parameter int unsigned PTR_REG  = 17,
    parameter int unsigned CMD_REG  = 46
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_we,
    input  logic [AW-1:0] dir_addr,
    input  logic [DW-1:0] dir_data,
    input  logic          ind_we,
    input  logic [DW-1:0] ind_data,
    input  logic          eng_done,
    output logic          rf_we,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_data,
    output logic [DW-1:0] ptr,
    output logic          cmd_start,
    output logic          cmd_abort,
    output logic          busy
);
    localparam int unsigned INH_BIT = DW - 1;

    typedef struct packed {
        logic [DW-1:0] ptr;
        logic          rf_we;
        logic [AW-1:0] rf_addr;
        logic [DW-1:0] rf_data;
        logic          start;
        logic          abort;
        logic          busy;
    } state_t;

    state_t st_d, st_q;

    wr_src_e       src;
    logic          wr_we;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          ind_accept;
    logic          ptr_load;
    logic [DW-1:0] ptr_nxt;
    logic          busy_nxt;
    logic          start_nxt;
    logic          abort_nxt;

    ind_wr_route #(
        .AW(AW), .DW(DW), .NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG)
    ) u_route (
        .dir_we     (dir_we),
        .dir_addr   (dir_addr),
        .dir_data   (dir_data),
        .ind_we     (ind_we),
        .ind_data   (ind_data),
        .ind_target (st_q.ptr[AW-1:0]),
        .src        (src),
        .we         (wr_we),
        .addr       (wr_addr),
        .data       (wr_data),
        .ind_accept (ind_accept),
        .ptr_load   (ptr_load)
    );

    ind_ptr_next #(
        .AW(AW), .DW(DW), .INH_BIT(INH_BIT)
    ) u_ptr (
        .ptr_q     (st_q.ptr),
        .load      (ptr_load),
        .load_data (dir_data),
        .advance   (ind_accept),
        .ptr_d     (ptr_nxt)
    );

    ind_cmd_ctl #(
        .AW(AW), .DW(DW), .CMD_REG(CMD_REG)
    ) u_cmd (
        .we       (wr_we),
        .addr     (wr_addr),
        .data     (wr_data),
        .busy_q   (st_q.busy),
        .eng_done (eng_done),
        .busy_d   (busy_nxt),
        .start_d  (start_nxt),
        .abort_d  (abort_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ptr     = ptr_nxt;
        st_d.rf_we   = wr_we;
        st_d.rf_addr = (src == SRC_NONE) ? st_q.rf_addr : wr_addr;
        st_d.rf_data = (src == SRC_NONE) ? st_q.rf_data : wr_data;
        st_d.start   = start_nxt;
        st_d.abort   = abort_nxt;
        st_d.busy    = busy_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_we     = st_q.rf_we;
    assign rf_addr   = st_q.rf_addr;
    assign rf_data   = st_q.rf_data;
    assign ptr       = st_q.ptr;
    assign cmd_start = st_q.start;
    assign cmd_abort = st_q.abort;
    assign busy      = st_q.busy;

endmodule

// File: rtl/ind_port_chk.sv
module ind_port_chk #(
    parameter int unsigned AW       = 6,
    parameter int unsigned DW       = 8,
    parameter int unsigned NUM_REGS = 47,
    parameter int unsigned PTR_REG  = 17,
    parameter int unsigned CMD_REG  = 46
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_we,
    input logic [AW-1:0] dir_addr,
    input logic          ind_we,
    input logic          eng_done,
    input logic          rf_we,
    input logic [AW-1:0] rf_addr,
    input logic [DW-1:0] ptr,
    input logic          cmd_start,
    input logic          cmd_abort,
    input logic          busy
);
    localparam int unsigned INH = DW - 1;

    // R2: the bit between flag and target always reads zero
    p_ptr_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr[DW-2]);

    // R3: a lone indirect write lands at the old pointer target
    p_ind_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ind_we && !dir_we |=> (!rf_we || rf_addr == $past(ptr[AW-1:0])));

    // R4: pointer advances by one when not inhibited
    p_ptr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ind_we && !dir_we && !ptr[INH] |=>
            ptr[AW-1:0] == $past(ptr[AW-1:0]) + AW'(1));

    // R4: pointer holds when inhibited
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ind_we && !dir_we && ptr[INH] |=> $stable(ptr));

    // R6: nothing outside the register file is ever written
    p_rf_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> 32'(rf_addr) < NUM_REGS);

    // R7: the data port never writes the pointer register
    p_no_self_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ind_we && !dir_we && ptr[AW-1:0] == AW'(PTR_REG) |=> !rf_we);

    // R8: a start pulse always comes with a command-register write and busy
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> busy && rf_we && rf_addr == AW'(CMD_REG));

    // R8: start is a single-cycle pulse for one write
    p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && !dir_we && !ind_we |=> !cmd_start);

    // R9: done with no command write clears busy
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !dir_we && !ind_we |=> !busy);

    // R10: abort only follows a busy engine
    p_abort_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |-> $past(busy));

    // R11: a simultaneous direct write freezes the pointer unless it loads it
    p_dir_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we && ind_we && dir_addr != AW'(PTR_REG) |=> $stable(ptr));

endmodule

bind ind_write_port ind_port_chk #(
    .AW(AW), .DW(DW), .NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG), .CMD_REG(CMD_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_we    (dir_we),
    .dir_addr  (dir_addr),
    .ind_we    (ind_we),
    .eng_done  (eng_done),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .ptr       (ptr),
    .cmd_start (cmd_start),
    .cmd_abort (cmd_abort),
    .busy      (busy)
);

// File: tb/tb_ind_write_port.sv
module tb_ind_write_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_we = 1'b0;
    logic [5:0] dir_addr = '0;
    logic [7:0] dir_data = '0;
    logic       ind_we = 1'b0;
    logic [7:0] ind_data = '0;
    logic       eng_done = 1'b0;
    logic       rf_we;
    logic [5:0] rf_addr;
    logic [7:0] rf_data;
    logic [7:0] ptr;
    logic       cmd_start;
    logic       cmd_abort;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_write_port dut (
        .clk(clk), .rst_n(rst_n),
        .dir_we(dir_we), .dir_addr(dir_addr), .dir_data(dir_data),
        .ind_we(ind_we), .ind_data(ind_data), .eng_done(eng_done),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data), .ptr(ptr),
        .cmd_start(cmd_start), .cmd_abort(cmd_abort), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Drive one cycle of strobes, return at the next falling edge.
    task automatic cyc(input bit dw, input logic [5:0] da, input logic [7:0] dd,
                       input bit iw, input logic [7:0] id, input bit done);
        @(negedge clk);
        dir_we = dw; dir_addr = da; dir_data = dd;
        ind_we = iw; ind_data = id; eng_done = done;
        @(negedge clk);
        dir_we = 1'b0; ind_we = 1'b0; eng_done = 1'b0;
    endtask

    task automatic dwr(input logic [5:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic iwr(input logic [7:0] d);
        cyc(1'b0, 6'd0, 8'h00, 1'b1, d, 1'b0);
    endtask

    task automatic t_reset;
        chk_eq("R1 ptr", ptr, 0);
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 rf_we", rf_we, 0);
        chk_eq("R1 start/abort", {cmd_start, cmd_abort}, 0);
    endtask

    task automatic t_ptr_load;
        dwr(6'd17, 8'hC5);
        chk_eq("R2 ptr load", ptr, 8'h85);
        dwr(6'd17, 8'h7F);
        chk_eq("R2 bit6 masked", ptr, 8'h3F);
    endtask

    task automatic t_burst;
        dwr(6'd17, 8'd32);
        for (int i = 0; i < 15; i++) begin
            logic [7:0] v;
            v = (i == 14) ? 8'hD0 : 8'(8'h40 + i);
            iwr(v);
            chk(rf_we && rf_addr == 6'(32 + i) && rf_data == v, "R3 burst write",
                {rf_we, rf_addr, rf_data}, {1'b1, 6'(32 + i), v});
            chk_eq("R4 advance", ptr, 32 + i + 1);
            if (i == 14) begin
                chk_eq("R8 start", cmd_start, 1);
                chk_eq("R8 busy", busy, 1);
            end else begin
                chk_eq("R8 no early start", cmd_start, 0);
            end
        end
        @(negedge clk);
        chk_eq("R8 start one cycle", cmd_start, 0);
        chk_eq("R3 strobe one cycle", rf_we, 0);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk_eq("R9 done clears busy", busy, 0);
    endtask

    task automatic t_inhibit;
        dwr(6'd17, 8'h85);
        iwr(8'hA1);
        chk(rf_we && rf_addr == 6'd5 && rf_data == 8'hA1, "R4 inhibit write",
            {rf_we, rf_addr, rf_data}, {1'b1, 6'd5, 8'hA1});
        iwr(8'hA2);
        chk_eq("R4 inhibit holds", ptr, 8'h85);
        chk_eq("R4 inhibit same target", rf_addr, 5);
    endtask

    task automatic t_wrap;
        dwr(6'd17, 8'd62);
        iwr(8'h11);
        chk_eq("R6 reg62 dropped", rf_we, 0);
        chk_eq("R6 ptr still advances", ptr, 63);
        iwr(8'h12);
        chk_eq("R6 reg63 dropped", rf_we, 0);
        chk_eq("R5 wrap to 0", ptr, 0);
        iwr(8'h13);
        chk(rf_we && rf_addr == 6'd0 && rf_data == 8'h13, "R5 write at 0",
            {rf_we, rf_addr, rf_data}, {1'b1, 6'd0, 8'h13});
        dwr(6'd50, 8'h99);
        chk_eq("R6 direct out-of-range dropped", rf_we, 0);
    endtask

    task automatic t_self;
        dwr(6'd17, 8'd16);
        iwr(8'hB0);
        chk_eq("R7 reg16 written", rf_addr, 16);
        iwr(8'h85);
        chk_eq("R7 no write to 17", rf_we, 0);
        chk_eq("R7 ptr not loaded", ptr, 18);
        iwr(8'hB2);
        chk(rf_we && rf_addr == 6'd18, "R7 next target 18",
            {rf_we, rf_addr}, {1'b1, 6'd18});
    endtask

    task automatic t_cmd;
        dwr(6'd46, 8'h70);
        chk_eq("R8 direct start", {cmd_start, busy, cmd_abort}, 3'b110);
        dwr(6'd46, 8'hE0);
        chk_eq("R10 abort and restart", {cmd_start, busy, cmd_abort}, 3'b111);
        dwr(6'd46, 8'h05);
        chk_eq("R10 stop", {cmd_start, busy, cmd_abort}, 3'b001);
        dwr(6'd46, 8'h00);
        chk_eq("R10 stop when idle", {cmd_start, busy, cmd_abort}, 3'b000);
        cyc(1'b1, 6'd46, 8'hD0, 1'b0, 8'h00, 1'b1);
        chk_eq("R9 start wins over done", busy, 1);
        cyc(1'b0, 6'd0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk_eq("R9 done later clears", busy, 0);
    endtask

    task automatic t_priority;
        dwr(6'd17, 8'd20);
        cyc(1'b1, 6'd5, 8'h11, 1'b1, 8'h22, 1'b0);
        chk(rf_we && rf_addr == 6'd5 && rf_data == 8'h11, "R11 direct wins",
            {rf_we, rf_addr, rf_data}, {1'b1, 6'd5, 8'h11});
        chk_eq("R11 ptr frozen", ptr, 20);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_load();
        t_burst();
        t_inhibit();
        t_wrap();
        t_self();
        t_cmd();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule